// File: doc/BRIEF.md
# Secure Serial Memory Access Engine

This block is the slave side of a three-wire serial link that guards a 384-bit secret store behind a 64-bit match code. The link has an active-high transfer enable, a serial clock and a data line. The data line is split into an input, an output and an output enable. The engine first shifts in a 24-bit command word and sorts it into one of the following:

- a normal read or write of the store,
- a program command that loads a fresh identification value and match code,
- a command for the external timer block,
- a rejected word, which silences the rest of the transfer.

A normal transfer begins by sending out the 64-bit identification value. It then takes in 64 bits and compares them with the stored match code. On equality, the next 384 cycles read or write the store. On a mismatch, a read sends pseudo-random bits from a free-running LFSR, and a write is ignored. Input bits are sampled on rising serial-clock edges. Output bits are driven from each falling edge until the next rising edge. Dropping the enable ends the transfer at once. A timer-side inhibit input blocks every write to the stored values.

Top module: `skey_engine`

## Requirements
- R1: After power reset, and whenever `xfer_en` is low, `dq_oe` is 0 and `tmr_active` is 0.
- R2: `dq_oe` is only ever 1 while `sclk` is low. Every rising edge returns the line to high impedance.
- R3: The command word is shifted in LSB first, as bits 0..23 = function byte, mode byte, tail byte. The only accepted 24-bit values are:
  - 0xB00162 for normal read,
  - 0xB0019D for normal write,
  - 0xB0029D for program,
  - 0xB002F1 through 0xB002F6 for timer commands.

  Any other value gives no output, no timer hand-off and no change to stored state for the rest of the transfer.
- R4: After a normal read or write command, cycles 24..87 drive the identification value, LSB first.
- R5: Cycles 88..151 take in a 64-bit compare value, LSB first. Access is granted only if every bit, including the last, equals the stored match code. The line is not driven in this window.
- R6: On a granted read, cycles 152..535 drive the 384 store bits, LSB first.
- R7: On a granted write, the bits input in cycles 152..535 replace the store, LSB first.
- R8: On a refused read, cycles 152..535 drive LFSR bits (a 16-bit maximal-length LFSR by default) in place of the store contents.
- R9: On a refused write, the store is left unchanged.
- R10: A program command clears the store. It then writes cycles 24..87 into the identification value and cycles 88..151 into the match code, each LSB first.
- R11: A timer command raises `tmr_active` with `tmr_func` equal to the function byte, from cycle 24 until the transfer ends. The engine never drives the line during it.
- R12: While `timer_inhibit` is 1, neither normal writes nor program commands (including the clear) change any stored value.
- R13: Cycles after cycle 535 have no effect and are never driven.
- R14: Dropping `xfer_en` ends the transfer at once. `dq_oe` falls without waiting for a clock edge, and the next transfer starts again from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low; clears stored values and LFSR |
| sclk | input | 1 | Serial clock |
| xfer_en | input | 1 | Transfer enable, active high; low aborts and idles the link |
| dq_in | input | 1 | Serial data from the host |
| dq_out | output | 1 | Serial data to the host |
| dq_oe | output | 1 | Drive enable for the data line |
| timer_inhibit | input | 1 | From the timer block: blocks all writes of stored values |
| tmr_active | output | 1 | The current transfer belongs to the timer block |
| tmr_func | output | 8 | Function byte of the timer command, zero otherwise |

## Verification
A wrong bit counter or phase state shows at the ports within one clock cycle. The drive enable rises or falls in the wrong slot, so the bench records `dq_oe` in every slot of every transfer and compares the windows. A bad store, identification or match-code bit stays hidden until the next transfer reads it. For that reason, every write, refused write, inhibited write, rejected command and overrun is followed by a full granted read. Errors in the compare path show as a granted read of garbage or a refused read of real data. Those are told apart by counting how many data bits differ from the model.

// File: rtl/skey_pkg.sv
package skey_pkg;

   localparam int CMD_W = 24;

   localparam logic [7:0] TAIL_BYTE  = 8'hB0;
   localparam logic [1:0] SEL_NORMAL = 2'b01;
   localparam logic [1:0] SEL_PROG   = 2'b10;

   localparam logic [7:0] FN_FETCH   = 8'h62;
   localparam logic [7:0] FN_STORE   = 8'h9D;
   localparam logic [7:0] FN_TMR_LO  = 8'hF1;
   localparam logic [7:0] FN_TMR_HI  = 8'hF6;

   typedef enum logic [2:0] {
      K_IDLE,
      K_ABORT,
      K_NRD,
      K_NWR,
      K_PROG,
      K_TIMER
   } kind_e;

endpackage

// File: rtl/skey_cmd_decode.sv
module skey_cmd_decode
   import skey_pkg::*;
(
   input  logic [CMD_W-1:0] word,
   output kind_e            kind
);

   logic [7:0] fn_b;
   logic [7:0] sel_b;
   logic [7:0] tail_b;
   logic       frame_ok;

   assign fn_b   = word[7:0];
   assign sel_b  = word[15:8];
   assign tail_b = word[23:16];

   assign frame_ok = (tail_b == TAIL_BYTE) && (sel_b[7:2] == 6'd0);

   always_comb begin
      kind = K_ABORT;
      if (frame_ok) begin
         unique case (sel_b[1:0])
            SEL_NORMAL: begin
               if (fn_b == FN_FETCH)      kind = K_NRD;
               else if (fn_b == FN_STORE) kind = K_NWR;
            end
            SEL_PROG: begin
               if (fn_b == FN_STORE)                              kind = K_PROG;
               else if (fn_b >= FN_TMR_LO && fn_b <= FN_TMR_HI)   kind = K_TIMER;
            end
            default: kind = K_ABORT;
         endcase
      end
   end

endmodule

// File: rtl/skey_bitreg.sv
module skey_bitreg #(
   parameter int W  = 64,
   localparam int IW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic          din,
   output logic [W-1:0]  q
);

   generate
      if (W < 2) begin : g_bad_w
         $error("skey_bitreg: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (we)
         q[idx] <= din;
   end

endmodule

// File: rtl/skey_garble_lfsr.sv
module skey_garble_lfsr #(
   parameter int           W    = 16,
   parameter logic [W-1:0] SEED = W'(1)
) (
   input  logic clk,
   input  logic rst_n,
   output logic bit_o
);

   logic [W-1:0] poly;
   logic [W-1:0] state;

   generate
      if (W == 8) begin : g_p8
         assign poly = W'(8'hB8);
      end else if (W == 16) begin : g_p16
         assign poly = W'(16'hB400);
      end else if (W == 32) begin : g_p32
         assign poly = W'(32'h8020_0003);
      end else begin : g_bad
         assign poly = '0;
         $error("skey_garble_lfsr: W must be 8, 16 or 32");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("skey_garble_lfsr: SEED must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= SEED;
      else if (state[0])
         state <= (state >> 1) ^ poly;
      else
         state <= state >> 1;
   end

   assign bit_o = state[0];

endmodule

// File: rtl/skey_engine.sv
module skey_engine
   import skey_pkg::*;
#(
   parameter int                ID_W      = 64,
   parameter int                KEY_W     = 64,
   parameter int                MEM_W     = 384,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(16'hACE1)
) (
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       xfer_en,
   input  logic       dq_in,
   output logic       dq_out,
   output logic       dq_oe,
   input  logic       timer_inhibit,
   output logic       tmr_active,
   output logic [7:0] tmr_func
);

   localparam int ID_BASE   = CMD_W;
   localparam int KEY_BASE  = ID_BASE + ID_W;
   localparam int DATA_BASE = KEY_BASE + KEY_W;
   localparam int END_CNT   = DATA_BASE + MEM_W;
   localparam int CNT_W     = $clog2(END_CNT + 1);
   localparam int ID_IW     = $clog2(ID_W);
   localparam int KEY_IW    = $clog2(KEY_W);
   localparam int MEM_IW    = $clog2(MEM_W);

   localparam logic [CNT_W-1:0] C_CMD_LAST = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] C_ID       = CNT_W'(ID_BASE);
   localparam logic [CNT_W-1:0] C_KEY      = CNT_W'(KEY_BASE);
   localparam logic [CNT_W-1:0] C_KEY_LAST = CNT_W'(DATA_BASE - 1);
   localparam logic [CNT_W-1:0] C_DATA     = CNT_W'(DATA_BASE);
   localparam logic [CNT_W-1:0] C_END      = CNT_W'(END_CNT);

   generate
      if (ID_W < 2 || KEY_W < 2 || MEM_W < 2) begin : g_bad_width
         $error("skey_engine: field widths must be at least 2");
      end
   endgenerate

   logic             xfer_rst_n;
   logic [CNT_W-1:0] cnt;
   logic [CMD_W-1:0] cmd_sr;
   logic [CMD_W-1:0] cmd_word;
   kind_e            kind_q;
   kind_e            dec_kind;
   logic             miss_q;
   logic             grant_q;
   logic             drive_q;
   logic             bit_q;

   logic             in_cmd, in_id, in_key, in_data;
   logic             cmd_last, key_last;
   logic             is_normal, key_chk, bit_miss;
   logic             wr_ok, clr_all, id_we, key_we, mem_we;
   logic             garble;

   logic [ID_IW-1:0]  id_idx;
   logic [KEY_IW-1:0] key_idx;
   logic [MEM_IW-1:0] mem_idx;

   logic [ID_W-1:0]   id_q;
   logic [KEY_W-1:0]  key_q;
   logic [MEM_W-1:0]  mem_q;

   assign xfer_rst_n = rst_n & xfer_en;

   // slot windows, by cycle count since enable
   assign in_cmd   = (cnt < C_ID);
   assign in_id    = (cnt >= C_ID)   && (cnt < C_KEY);
   assign in_key   = (cnt >= C_KEY)  && (cnt < C_DATA);
   assign in_data  = (cnt >= C_DATA) && (cnt < C_END);
   assign cmd_last = (cnt == C_CMD_LAST);
   assign key_last = (cnt == C_KEY_LAST);

   assign id_idx  = ID_IW'(cnt - C_ID);
   assign key_idx = KEY_IW'(cnt - C_KEY);
   assign mem_idx = MEM_IW'(cnt - C_DATA);

   assign cmd_word = {dq_in, cmd_sr[CMD_W-1:1]};

   skey_cmd_decode u_dec (
      .word (cmd_word),
      .kind (dec_kind)
   );

   assign is_normal = (kind_q == K_NRD) || (kind_q == K_NWR);
   assign key_chk   = in_key && is_normal;
   assign bit_miss  = (dq_in != key_q[key_idx]);

   // rising-edge side: counter, command shift, compare
   always_ff @(posedge sclk or negedge xfer_rst_n) begin
      if (!xfer_rst_n) begin
         cnt     <= '0;
         cmd_sr  <= '0;
         kind_q  <= K_IDLE;
         miss_q  <= 1'b0;
         grant_q <= 1'b0;
      end else begin
         if (cnt != C_END)
            cnt <= cnt + 1'b1;
         if (in_cmd)
            cmd_sr <= cmd_word;
         if (cmd_last)
            kind_q <= dec_kind;
         if (key_chk)
            miss_q <= miss_q | bit_miss;
         if (key_chk && key_last)
            grant_q <= !(miss_q | bit_miss);
      end
   end

   // stored values
   assign wr_ok   = !timer_inhibit;
   assign clr_all = cmd_last && (dec_kind == K_PROG) && wr_ok;
   assign id_we   = (kind_q == K_PROG) && in_id  && wr_ok;
   assign key_we  = (kind_q == K_PROG) && in_key && wr_ok;
   assign mem_we  = (kind_q == K_NWR) && grant_q && in_data && wr_ok;

   skey_bitreg #(.W(ID_W)) u_id (
      .clk (sclk), .rst_n (rst_n), .clr (clr_all), .we (id_we),
      .idx (id_idx), .din (dq_in), .q (id_q)
   );

   skey_bitreg #(.W(KEY_W)) u_key (
      .clk (sclk), .rst_n (rst_n), .clr (clr_all), .we (key_we),
      .idx (key_idx), .din (dq_in), .q (key_q)
   );

   skey_bitreg #(.W(MEM_W)) u_mem (
      .clk (sclk), .rst_n (rst_n), .clr (clr_all), .we (mem_we),
      .idx (mem_idx), .din (dq_in), .q (mem_q)
   );

   skey_garble_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (sclk),
      .rst_n (rst_n),
      .bit_o (garble)
   );

   // falling-edge side: output launch
   always_ff @(negedge sclk or negedge xfer_rst_n) begin
      if (!xfer_rst_n) begin
         drive_q <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         drive_q <= 1'b0;
         bit_q   <= 1'b0;
         if (is_normal && in_id) begin
            drive_q <= 1'b1;
            bit_q   <= id_q[id_idx];
         end else if ((kind_q == K_NRD) && in_data) begin
            drive_q <= 1'b1;
            bit_q   <= grant_q ? mem_q[mem_idx] : garble;
         end
      end
   end

   assign dq_oe      = drive_q & ~sclk;
   assign dq_out     = bit_q & dq_oe;
   assign tmr_active = (kind_q == K_TIMER);
   assign tmr_func   = tmr_active ? cmd_sr[7:0] : 8'h00;

endmodule

// File: rtl/skey_engine_chk.sv
module skey_engine_chk
   import skey_pkg::*;
#(
   parameter int MEM_W     = 384,
   parameter int CNT_W     = 10,
   parameter int KEY_BASE  = 88,
   parameter int DATA_BASE = 152,
   parameter int END_CNT   = 536
) (
   input logic             rst_n,
   input logic             sclk,
   input logic             xfer_en,
   input logic             timer_inhibit,
   input logic             tmr_active,
   input logic             drive_q,
   input logic             grant_q,
   input kind_e            kind_q,
   input logic [CNT_W-1:0] cnt,
   input logic [MEM_W-1:0] mem_q
);

   localparam logic [CNT_W-1:0] L_KEY  = CNT_W'(KEY_BASE);
   localparam logic [CNT_W-1:0] L_DATA = CNT_W'(DATA_BASE);
   localparam logic [CNT_W-1:0] L_END  = CNT_W'(END_CNT);

   assert_abort_silent_R3: assert property (@(posedge sclk)
      disable iff (!rst_n || !xfer_en)
      (kind_q == K_ABORT) |-> (!drive_q && !tmr_active));

   assert_no_drive_in_key_R5: assert property (@(posedge sclk)
      disable iff (!rst_n || !xfer_en)
      (cnt >= L_KEY && cnt < L_DATA) |-> !drive_q);

   assert_refused_write_R9: assert property (@(posedge sclk)
      disable iff (!rst_n)
      (kind_q == K_NWR && !grant_q) |=> $stable(mem_q));

   assert_timer_hands_off_R11: assert property (@(posedge sclk)
      disable iff (!rst_n || !xfer_en)
      tmr_active |-> !drive_q);

   assert_inhibit_holds_mem_R12: assert property (@(posedge sclk)
      disable iff (!rst_n)
      timer_inhibit |=> $stable(mem_q));

   assert_count_saturates_R13: assert property (@(posedge sclk)
      disable iff (!rst_n || !xfer_en)
      (cnt == L_END) |=> (cnt == L_END));

endmodule

bind skey_engine skey_engine_chk #(
   .MEM_W     (MEM_W),
   .CNT_W     (CNT_W),
   .KEY_BASE  (KEY_BASE),
   .DATA_BASE (DATA_BASE),
   .END_CNT   (END_CNT)
) u_chk (
   .rst_n         (rst_n),
   .sclk          (sclk),
   .xfer_en       (xfer_en),
   .timer_inhibit (timer_inhibit),
   .tmr_active    (tmr_active),
   .drive_q       (drive_q),
   .grant_q       (grant_q),
   .kind_q        (kind_q),
   .cnt           (cnt),
   .mem_q         (mem_q)
);

// File: tb/skey_engine_test.sv
`timescale 1ns/1ps
module skey_engine_test;

   localparam int NSLOT = 600;
   localparam int FULL  = 536;

   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       xfer_en = 1'b0;
   logic       dq_in = 1'b0;
   logic       dq_out;
   logic       dq_oe;
   logic       timer_inhibit = 1'b0;
   logic       tmr_active;
   logic [7:0] tmr_func;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   bit         tin  [NSLOT];
   bit         tq   [NSLOT];
   bit         toe  [NSLOT];
   bit         tact [NSLOT];
   logic [7:0] tfn  [NSLOT];
   bit         hi_err = 0;
   bit         end_oe = 0;

   bit [63:0]  id_m, key_m;
   bit [383:0] mem_m;

   skey_engine uut (
      .rst_n (rst_n), .sclk (sclk), .xfer_en (xfer_en), .dq_in (dq_in),
      .dq_out (dq_out), .dq_oe (dq_oe), .timer_inhibit (timer_inhibit),
      .tmr_active (tmr_active), .tmr_func (tmr_func)
   );

   always #5 sclk = ~sclk;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit [63:0] rand64();
      return {$urandom(), $urandom()};
   endfunction

   function automatic bit [383:0] rand384();
      bit [383:0] v;
      for (int i = 0; i < 12; i++) v[i*32 +: 32] = $urandom();
      return v;
   endfunction

   task automatic clear_tin();
      for (int i = 0; i < NSLOT; i++) tin[i] = 0;
   endtask

   task automatic put(input int base, input int w, input bit [383:0] v);
      for (int i = 0; i < w; i++) tin[base + i] = v[i];
   endtask

   function automatic bit [63:0] got64(input int base);
      bit [63:0] v;
      for (int i = 0; i < 64; i++) v[i] = tq[base + i];
      return v;
   endfunction

   function automatic bit [383:0] got384();
      bit [383:0] v;
      for (int i = 0; i < 384; i++) v[i] = tq[152 + i];
      return v;
   endfunction

   function automatic int oe_count(input int lo, input int hi);
      int n = 0;
      for (int i = lo; i < hi; i++) n += toe[i];
      return n;
   endfunction

   // slot i = i-th clock cycle after enable; output valid while sclk low
   task automatic run(input int n);
      @(posedge sclk);
      #1 xfer_en = 1'b1;
      for (int i = 0; i < NSLOT; i++) begin
         toe[i] = 0; tq[i] = 0; tact[i] = 0; tfn[i] = 0;
      end
      for (int i = 0; i < n; i++) begin
         @(negedge sclk);
         #1 dq_in = tin[i];
         #3 tq[i] = dq_out; toe[i] = dq_oe; tact[i] = tmr_active; tfn[i] = tmr_func;
         #2 if (dq_oe) hi_err = 1;
      end
      @(negedge sclk);
      #1 xfer_en = 1'b0;
      #1 end_oe = dq_oe;
      dq_in = 1'b0;
      repeat (2) @(posedge sclk);
   endtask

   task automatic do_prog(input bit [63:0] id, input bit [63:0] key);
      clear_tin();
      put(0, 24, 384'h B0029D);
      put(24, 64, 384'(id));
      put(88, 64, 384'(key));
      run(152);
   endtask

   task automatic do_norm(input bit wr, input bit [63:0] key, input bit [383:0] d, input int n);
      clear_tin();
      put(0, 24, wr ? 384'h B0019D : 384'h B00162);
      put(88, 64, 384'(key));
      if (wr) put(152, 384, d);
      run(n);
   endtask

   task automatic verify_read(input string req);
      do_norm(0, key_m, '0, FULL);
      check(got64(24) == id_m && oe_count(24, 88) == 64, req, got64(24), id_m);
      check(got384() == mem_m && oe_count(152, FULL) == 384, req,
            got384() == mem_m ? 0 : 1, 0);
   endtask

   initial begin
      bit [23:0] bad [8];
      bit [63:0] k2, id2;
      bit [383:0] d;
      int diff;

      void'($urandom(32'd7741));
      bad[0] = 24'hB00362; bad[1] = 24'hB0009D; bad[2] = 24'hB1019D; bad[3] = 24'hA0019D;
      bad[4] = 24'hB0059D; bad[5] = 24'hB00163; bad[6] = 24'hB00262; bad[7] = 24'hB001F3;

      #23;
      check(dq_oe == 0 && tmr_active == 0, "R1 reset", {dq_oe, tmr_active}, 0);
      rst_n = 1'b1;
      repeat (3) @(posedge sclk);
      #2 check(dq_oe == 0, "R1 idle", dq_oe, 0);

      // program identification and match code
      id_m = rand64(); key_m = rand64(); mem_m = '0;
      do_prog(id_m, key_m);
      check(oe_count(0, 152) == 0, "R10 silent", oe_count(0, 152), 0);

      // granted write then read
      mem_m = rand384();
      do_norm(1, key_m, mem_m, FULL);
      check(got64(24) == id_m, "R4 id out", got64(24), id_m);
      check(oe_count(88, 152) == 0, "R5 no drive in key", oe_count(88, 152), 0);
      check(oe_count(152, FULL) == 0, "R7 write not driven", oe_count(152, FULL), 0);
      verify_read("R6 R7 granted");

      // refused write, mismatch in last match bit only
      k2 = key_m ^ 64'h8000_0000_0000_0000;
      do_norm(1, k2, rand384(), FULL);
      verify_read("R5 R9 last-bit miss write");
      // refused write, random mismatch
      do_norm(1, key_m ^ (64'd1 << ($urandom() % 64)), rand384(), FULL);
      verify_read("R9 random miss write");

      // refused read: garbled
      do_norm(0, key_m ^ 64'h1, '0, FULL);
      check(got64(24) == id_m, "R4 id before refusal", got64(24), id_m);
      diff = 0;
      d = got384();
      for (int i = 0; i < 384; i++) diff += (d[i] != mem_m[i]);
      check(oe_count(152, FULL) == 384 && diff > 96 && d != '0 && d != '1,
            "R8 garbled", diff, 192);

      // rejected command words
      for (int b = 0; b < 8; b++) begin
         clear_tin();
         put(0, 24, 384'(bad[b]));
         put(24, 64, 384'(rand64()));
         put(88, 64, 384'(key_m));
         put(152, 384, rand384());
         run(FULL);
         check(oe_count(0, FULL) == 0 && tact[100] == 0, "R3 reject", bad[b], 0);
      end
      verify_read("R3 state kept");

      // timer command hand-off
      clear_tin();
      put(0, 24, 384'h B002F3);
      put(24, 9, 384'h1A5);
      run(40);
      check(tact[30] == 1 && tfn[30] == 8'hF3, "R11 timer", {tact[30], tfn[30]}, 9'h1F3);
      check(tact[10] == 0 && oe_count(0, 40) == 0, "R11 no drive", oe_count(0, 40), 0);
      #2 check(tmr_active == 0 && tmr_func == 0, "R1 after timer", tmr_func, 0);

      // inhibit blocks normal writes and program
      timer_inhibit = 1'b1;
      do_norm(1, key_m, rand384(), FULL);
      do_prog(rand64(), rand64());
      timer_inhibit = 1'b0;
      verify_read("R12 inhibit");

      // overrun beyond the last slot
      mem_m = rand384();
      do_norm(1, key_m, mem_m, NSLOT);
      for (int i = FULL; i < NSLOT; i++) tin[i] = $urandom() % 2;
      do_norm(0, key_m, '0, NSLOT);
      check(got384() == mem_m, "R13 overrun data", got384() == mem_m, 1);
      check(oe_count(FULL, NSLOT) == 0, "R13 tail silent", oe_count(FULL, NSLOT), 0);

      // early termination mid identification
      do_norm(0, key_m, '0, 30);
      check(end_oe == 0, "R14 drop", end_oe, 0);
      check(oe_count(24, 30) == 6 && tq[29] == id_m[5], "R14 partial", tq[29], id_m[5]);
      verify_read("R14 restart");

      // program clears store
      id2 = rand64(); k2 = rand64();
      do_prog(id2, k2);
      id_m = id2; key_m = k2; mem_m = '0;
      verify_read("R10 erase and load");

      // random write/read rounds
      for (int r = 0; r < 3; r++) begin
         mem_m = rand384();
         do_norm(1, key_m, mem_m, FULL);
         verify_read("R7 random round");
      end

      check(!hi_err, "R2 high phase", hi_err, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule